// File: doc/BRIEF.md
# Inter-Hart Software Interrupt Bank

This block gives each hart in a cluster one 32-bit memory-mapped word. A hart sends a software interrupt to another hart by writing that hart's word, and the bank drives one interrupt output per hart. Register access uses a 32-bit little-endian request bus. Only full-word accesses are decoded. A read answers one cycle after the request.

The bank is built in one of two modes, chosen at elaboration. In level mode each word holds a pending flag. Writing bit 0 sets or clears the flag, the flag drives the hart's interrupt line directly, and software can read the flag back. In set-only mode a word holds no state. Writing 1 to bit 0 sends a single-cycle set pulse to the hart's pending logic, writing 0 does nothing, and every read returns zero. In set-only mode, clearing the interrupt is left to the receiving core.

Top module: `swi_bank`

## Requirements
- R1: The word for hart h sits at byte offset 4·h. A legal write with bit 0 = 1 to that word raises `irq_o[h]` from the next clock edge and leaves every other hart's output unchanged.
- R2: In level mode, a legal write with bit 0 = 0 lowers `irq_o[h]` from the next clock edge.
- R3: Bits 31..1 of the write data are ignored. Only bit 0 decides between set and clear.
- R4: A read request sets `bus_rvalid` for exactly the following cycle. In that cycle, in level mode, `bus_rdata` carries the hart's pending flag in bit 0 and zeros in bits 31..1.
- R5: In set-only mode, a legal write of 1 drives `irq_o[h]` high for exactly one cycle, then low again unless it is written again.
- R6: In set-only mode, a write of 0 leaves the outputs low, and every read returns 0.
- R7: Reset (`rst_n` low) clears every pending flag and `bus_rvalid`. All interrupt outputs are low after reset.
- R8: An access whose address bits [1:0] are not 00 is ignored when it is a write and reads as 0.
- R9: An access at an offset of NUM_HARTS·4 or higher is ignored when it is a write and reads as 0.
- R10: An access whose byte enables are not all four set (`bus_be` ≠ 4'hF) is ignored when it is a write and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_be | input | 4 | Byte enables, little-endian lanes |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after a read request |
| bus_rdata | output | 32 | Read response data |
| irq_o | output | NUM_HARTS | Software interrupt per hart (a level in level mode, a pulse in set-only mode) |

## Verification
The assertions check the following on every cycle:
- A write selects at most one hart.
- In level mode, a set or clear takes effect on the next edge, and a flag holds its value when its hart is not written.
- In set-only mode, a pulse appears only after a set write.
- Read data never has a bit above bit 0 set, and a rejected access always reads as zero.

Only the bench scenarios show the following:
- The mapping from offsets to individual harts.
- The exact one-cycle width of a set-only pulse.
- The rejection of misaligned, partial-width and out-of-range accesses as seen at the outputs.
- The clearing of set flags by a reset asserted mid-run.

// File: rtl/swi_pkg.sv
package swi_pkg;

    localparam int BUS_DW = 32;
    localparam int BUS_BW = BUS_DW / 8;

    typedef enum logic {
        MODE_LEVEL   = 1'b0,
        MODE_SETONLY = 1'b1
    } swi_mode_e;

    typedef struct packed {
        logic flag;
    } cell_state_t;

    typedef struct packed {
        logic              rvalid;
        logic [BUS_DW-1:0] rdata;
    } rd_state_t;

endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                      req_i,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [swi_pkg::BUS_BW-1:0] be_i,
    output logic                      legal_o,
    output logic [NUM_HARTS-1:0]      wr_sel_o,
    output logic [NUM_HARTS-1:0]      rd_sel_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] WORD_LIMIT = WORD_W'(NUM_HARTS);

    logic [WORD_W-1:0]    word;
    logic                 aligned;
    logic                 full_width;
    logic                 in_range;
    logic [NUM_HARTS-1:0] hit;

    always_comb begin
        word       = addr_i[ADDR_W-1:2];
        aligned    = (addr_i[1:0] == 2'b00);
        full_width = (be_i == {swi_pkg::BUS_BW{1'b1}});
        in_range   = (word < WORD_LIMIT);
        legal_o    = req_i && aligned && full_width && in_range;
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hit
        always_comb begin
            hit[h]      = legal_o && (word == WORD_W'(h));
            wr_sel_o[h] = hit[h] && we_i;
            rd_sel_o[h] = hit[h] && !we_i;
        end
    end

endmodule

// File: rtl/swi_hart_cell.sv
module swi_hart_cell #(
    parameter swi_pkg::swi_mode_e MODE = swi_pkg::MODE_LEVEL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic wr_bit_i,
    output logic irq_o,
    output logic pend_o
);
    import swi_pkg::*;

    cell_state_t cell_d, cell_q;

    if (MODE == MODE_LEVEL) begin : g_level
        always_comb begin
            cell_d = cell_q;
            if (wr_en_i) begin
                cell_d.flag = wr_bit_i;
            end
        end
        assign pend_o = cell_q.flag;

        // R1: a set write raises the line on the next edge
        a_r1_set_raises : assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i && wr_bit_i |=> irq_o);
        // R2: a clear write lowers the line on the next edge
        a_r2_clear_lowers : assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i && !wr_bit_i |=> !irq_o);
        // R1: a hart that is not written keeps its level
        a_r1_hold_unwritten : assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en_i |=> $stable(irq_o));
    end else begin : g_setonly
        always_comb begin
            cell_d      = cell_q;
            cell_d.flag = wr_en_i && wr_bit_i;
        end
        assign pend_o = 1'b0;

        // R5: a pulse only ever follows a set write
        a_r5_pulse_cause : assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> $past(wr_en_i && wr_bit_i));
        // R6: writing zero produces no pulse
        a_r6_zero_inert : assert property (@(posedge clk) disable iff (!rst_n)
            wr_en_i && !wr_bit_i |=> !irq_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign irq_o = cell_q.flag;

endmodule

// File: rtl/swi_read_port.sv
module swi_read_port #(
    parameter int                 NUM_HARTS = 4,
    parameter swi_pkg::swi_mode_e MODE      = swi_pkg::MODE_LEVEL
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_i,
    input  logic                       we_i,
    input  logic                       legal_i,
    input  logic [NUM_HARTS-1:0]       rd_sel_i,
    input  logic [NUM_HARTS-1:0]       pend_i,
    output logic                       rvalid_o,
    output logic [swi_pkg::BUS_DW-1:0] rdata_o
);
    import swi_pkg::*;

    rd_state_t rd_d, rd_q;
    logic      sel_bit;

    always_comb begin
        sel_bit     = |(rd_sel_i & pend_i);
        rd_d        = '0;
        rd_d.rvalid = req_i && !we_i;
        if (MODE == MODE_LEVEL) begin
            rd_d.rdata[0] = sel_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rvalid_o = rd_q.rvalid;
    assign rdata_o  = rd_q.rdata;

    // R4: only bit 0 of a response may be set
    a_r4_upper_zero : assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (rdata_o[BUS_DW-1:1] == '0));
    // R4: a read request is answered on the next cycle
    a_r4_answer_next : assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !we_i |=> rvalid_o);
    // R9: a rejected access reads as zero
    a_r9_reject_zero : assert property (@(posedge clk) disable iff (!rst_n)
        req_i && !we_i && !legal_i |=> (rdata_o == '0));

    if (MODE == MODE_SETONLY) begin : g_sup_chk
        // R6: set-only mode always reads zero
        a_r6_read_zero : assert property (@(posedge clk) disable iff (!rst_n)
            rvalid_o |-> (rdata_o == '0));
    end

endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
    parameter int                 NUM_HARTS = 4,
    parameter int                 ADDR_W    = 12,
    parameter swi_pkg::swi_mode_e MODE      = swi_pkg::MODE_LEVEL
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    output logic                 bus_rvalid,
    output logic [31:0]          bus_rdata,
    output logic [NUM_HARTS-1:0] irq_o
);
    localparam int MIN_ADDR_W = $clog2(NUM_HARTS * 4) + 1;

    logic                 legal;
    logic [NUM_HARTS-1:0] wr_sel;
    logic [NUM_HARTS-1:0] rd_sel;
    logic [NUM_HARTS-1:0] pend;
    logic                 unused_wdata_hi;

    initial begin
        if (ADDR_W < MIN_ADDR_W) begin
            $error("swi_bank: ADDR_W too small for NUM_HARTS");
        end
    end

    assign unused_wdata_hi = ^bus_wdata[31:1];

    swi_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .req_i    (bus_req),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .be_i     (bus_be),
        .legal_o  (legal),
        .wr_sel_o (wr_sel),
        .rd_sel_o (rd_sel)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_cell
        swi_hart_cell #(
            .MODE (MODE)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (wr_sel[h]),
            .wr_bit_i (bus_wdata[0]),
            .irq_o    (irq_o[h]),
            .pend_o   (pend[h])
        );
    end

    swi_read_port #(
        .NUM_HARTS (NUM_HARTS),
        .MODE      (MODE)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (bus_req),
        .we_i     (bus_we),
        .legal_i  (legal),
        .rd_sel_i (rd_sel),
        .pend_i   (pend),
        .rvalid_o (bus_rvalid),
        .rdata_o  (bus_rdata)
    );

    // R1: a write reaches at most one hart
    a_r1_single_target : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
    // R10: partial-width accesses select nothing
    a_r10_partial_reject : assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_be != 4'hF) |-> (wr_sel == '0) && (rd_sel == '0));

endmodule

// File: tb/tb_swi_bank.sv
module tb_swi_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NH         = 4;
    localparam int AW         = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = 4'hF;
    logic [31:0]   bus_wdata = '0;
    logic          rv_m, rv_s;
    logic [31:0]   rd_m, rd_s;
    logic [NH-1:0] irq_m, irq_s;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(swi_pkg::MODE_LEVEL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rvalid(rv_m), .bus_rdata(rd_m), .irq_o(irq_m));

    swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .MODE(swi_pkg::MODE_SETONLY)) dut_s (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rvalid(rv_s), .bus_rdata(rd_s), .irq_o(irq_s));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [3:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_be = 4'hF;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        check("R7 irq level after reset", 32'(irq_m), 0);
        check("R7 irq setonly after reset", 32'(irq_s), 0);
        check("R7 rvalid after reset", 32'(rv_m), 0);
        for (int h = 0; h < NH; h++) begin
            rd(AW'(4 * h), 4'hF);
            check("R7 flag read after reset", rd_m, 0);
        end
    endtask

    task automatic t_set_and_read();
        wr(12'h008, 32'h1, 4'hF);
        check("R1 set hart2", 32'(irq_m), 32'h4);
        wr(12'h000, 32'h1, 4'hF);
        check("R1 set hart0", 32'(irq_m), 32'h5);
        rd(12'h008, 4'hF);
        check("R4 rvalid", 32'(rv_m), 1);
        check("R4 read hart2", rd_m, 1);
        rd(12'h004, 4'hF);
        check("R4 read hart1", rd_m, 0);
        idle();
        check("R4 rvalid drops", 32'(rv_m), 0);
    endtask

    task automatic t_clear_and_bits();
        wr(12'h008, 32'h0, 4'hF);
        check("R2 clear hart2", 32'(irq_m), 32'h1);
        wr(12'h000, 32'hFFFF_FFFE, 4'hF);
        check("R3 upper ones with bit0 clear", 32'(irq_m), 32'h0);
        wr(12'h00C, 32'h8000_0001, 4'hF);
        check("R3 bit0 set with noise", 32'(irq_m), 32'h8);
        rd(12'h00C, 4'hF);
        check("R4 read hart3", rd_m, 1);
    endtask

    task automatic t_rejects();
        wr(12'h005, 32'h1, 4'hF);
        check("R8 misaligned write ignored", 32'(irq_m), 32'h8);
        check("R8 misaligned no pulse", 32'(irq_s), 0);
        wr(12'h00E, 32'h0, 4'hF);
        check("R8 misaligned clear ignored", 32'(irq_m), 32'h8);
        rd(12'h00D, 4'hF);
        check("R8 misaligned read", rd_m, 0);
        wr(12'h010, 32'h1, 4'hF);
        check("R9 at limit ignored", 32'(irq_m), 32'h8);
        wr(12'h100, 32'h1, 4'hF);
        check("R9 far write ignored", 32'(irq_m), 32'h8);
        check("R9 no pulse", 32'(irq_s), 0);
        rd(12'h010, 4'hF);
        check("R9 read at limit", rd_m, 0);
        wr(12'h00C, 32'h0, 4'h1);
        check("R10 partial clear ignored", 32'(irq_m), 32'h8);
        wr(12'h004, 32'h1, 4'h7);
        check("R10 partial set ignored", 32'(irq_m), 32'h8);
        rd(12'h00C, 4'h3);
        check("R10 partial read", rd_m, 0);
    endtask

    task automatic t_setonly();
        wr(12'h004, 32'h1, 4'hF);
        check("R5 pulse hart1", 32'(irq_s), 32'h2);
        idle();
        check("R5 pulse ends", 32'(irq_s), 0);
        wr(12'h004, 32'h0, 4'hF);
        check("R6 zero write inert", 32'(irq_s), 0);
        idle();
        check("R6 zero write stays low", 32'(irq_s), 0);
        wr(12'h00C, 32'h1, 4'hF);
        rd(12'h00C, 4'hF);
        check("R6 read zero", rd_s, 0);
        check("R6 rvalid", 32'(rv_s), 1);
        check("R4 level mode still reads", rd_m, 1);
    endtask

    task automatic t_midrun_reset();
        wr(12'h000, 32'h1, 4'hF);
        wr(12'h004, 32'h1, 4'hF);
        check("R1 flags before reset", 32'(irq_m), 32'hB);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R7 midrun clear", 32'(irq_m), 0);
        @(negedge clk); rst_n = 1'b1;
        rd(12'h00C, 4'hF);
        check("R7 read after midrun reset", rd_m, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_set_and_read();
        t_clear_and_bits();
        t_rejects();
        t_setonly();
        t_midrun_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule